// File: doc/BRIEF.md
# Register Result-Latency Scoreboard

This block sits at the issue point of a small in-order core whose back end has three stages: execute, memory and write. It keeps one countdown per architectural register. The countdown holds the number of cycles left before the pending result in that register can be read. Each cycle, the front end presents one instruction. The instruction carries a class code, a mask of the registers it writes, and up to two source register indices. The block answers in the same cycle with a stall. An instruction issues in a cycle where it is valid and the stall is low.

A result with latency L can be read by an instruction issued L cycles after the producer. The countdown is therefore loaded with L-1 when the producer issues, and it falls by one each cycle until it reaches zero. Some classes also hold the execute stage for extra cycles. While execute is held, every valid instruction is stalled. A store has one shortcut: when a single-word load writes the register that the store uses as its data operand, the store may issue in the very next cycle. The store gets no such shortcut on its address operand.

A two-state controller tracks execute occupancy. In ST_FREE, execute is available. An issuing class with extra execute cycles moves the controller to ST_HOLD, which stalls all issue. ST_HOLD returns to ST_FREE once the extra cycles are spent.

Top module: `scb_scoreboard`

## Requirements
- R1: A synchronous reset clears every countdown and returns the controller to ST_FREE, so from the cycle after reset no instruction stalls.
- R2: The stall output is low whenever iss_valid is low.
- R3: Class 0 (plain ALU, or ALU with a constant shift) has result latency 1: a reader issued in the next cycle does not stall.
- R4: Class 1 (ALU with register-specified shift) holds execute for one extra cycle, so any valid instruction in the next cycle stalls. Its result latency is 2.
- R5: Class 2 (single word or byte load) has result latency 2: a reader in the next cycle stalls, and a reader one cycle later issues.
- R6: Class 4 (store) takes its address from source 0 and its data from source 1. If source 1 was written by a class 2 load issued in the immediately preceding cycle, the store issues without stalling. If source 0 was written by that load, the store stalls.
- R7: Class 3 (load of three or four registers) holds execute for two extra cycles and has result latency 3 on every register in its mask.
- R8: Class 5 (branch) and class 4 (store) leave every countdown unchanged and do not hold execute. Class 7 does the same.
- R9: Class 6 (call) has result latency 32: a reader stalls for 31 cycles and issues on the 32nd cycle after the call.
- R10: A newly issued writer replaces the destination's countdown with its own latency, even if an older result is still pending.
- R11: A source whose valid bit is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 3 | Instruction class code (see requirements) |
| iss_dst_mask | input | NREGS | One bit for each destination register written |
| iss_src0_vld | input | 1 | Source 0 is used |
| iss_src0 | input | IDXW | Source 0 index (store address) |
| iss_src1_vld | input | 1 | Source 1 is used |
| iss_src1 | input | IDXW | Source 1 index (store data) |
| iss_stall | output | 1 | Offered instruction must wait this cycle |

## Verification
The bench uses the default build: 16 registers, a 32-cycle call latency, and execute occupancies of 2 and 3 cycles. With the random sources drawn from only six registers, read-after-write hazards, overwrites and load-to-store pairs occur constantly. The defaults also bring the full 31-cycle call countdown and both execute-hold lengths within reach of a short run.

// File: rtl/scb_pkg.sv
package scb_pkg;

    typedef enum logic [2:0] {
        CLS_ALU       = 3'd0,
        CLS_ALU_SHREG = 3'd1,
        CLS_LOAD1     = 3'd2,
        CLS_LOADM     = 3'd3,
        CLS_STORE     = 3'd4,
        CLS_BRANCH    = 3'd5,
        CLS_CALL      = 3'd6,
        CLS_NOP       = 3'd7
    } op_class_e;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HOLD = 1'b1
    } exec_state_e;

endpackage

// File: rtl/scb_class_decode.sv
module scb_class_decode
    import scb_pkg::*;
#(
    parameter int CNTW       = 6,
    parameter int HW         = 2,
    parameter int LAT_ALU    = 1,
    parameter int LAT_SHREG  = 2,
    parameter int LAT_LOAD1  = 2,
    parameter int LAT_LOADM  = 3,
    parameter int LAT_CALL   = 32,
    parameter int SHREG_EXEC = 2,
    parameter int LOADM_EXEC = 3
) (
    input  op_class_e         cls,
    output logic [CNTW-1:0]   wait_init,
    output logic              writes,
    output logic              fwd_src,
    output logic              store_op,
    output logic [HW-1:0]     extra_busy
);

    localparam logic [CNTW-1:0] W_ALU   = CNTW'(LAT_ALU - 1);
    localparam logic [CNTW-1:0] W_SHREG = CNTW'(LAT_SHREG - 1);
    localparam logic [CNTW-1:0] W_LOAD1 = CNTW'(LAT_LOAD1 - 1);
    localparam logic [CNTW-1:0] W_LOADM = CNTW'(LAT_LOADM - 1);
    localparam logic [CNTW-1:0] W_CALL  = CNTW'(LAT_CALL - 1);
    localparam logic [HW-1:0]   X_SHREG = HW'(SHREG_EXEC - 1);
    localparam logic [HW-1:0]   X_LOADM = HW'(LOADM_EXEC - 1);

    always_comb begin
        wait_init  = '0;
        writes     = 1'b0;
        fwd_src    = 1'b0;
        store_op   = 1'b0;
        extra_busy = '0;
        unique case (cls)
            CLS_ALU: begin
                wait_init = W_ALU;
                writes    = 1'b1;
            end
            CLS_ALU_SHREG: begin
                wait_init  = W_SHREG;
                writes     = 1'b1;
                extra_busy = X_SHREG;
            end
            CLS_LOAD1: begin
                wait_init = W_LOAD1;
                writes    = 1'b1;
                fwd_src   = 1'b1;
            end
            CLS_LOADM: begin
                wait_init  = W_LOADM;
                writes     = 1'b1;
                extra_busy = X_LOADM;
            end
            CLS_STORE: begin
                store_op = 1'b1;
            end
            CLS_BRANCH: begin
                writes = 1'b0;
            end
            CLS_CALL: begin
                wait_init = W_CALL;
                writes    = 1'b1;
            end
            CLS_NOP: begin
                writes = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scb_reg_timers.sv
module scb_reg_timers #(
    parameter int NREGS = 16,
    parameter int CNTW  = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [NREGS-1:0]            wr_mask,
    input  logic [CNTW-1:0]             wait_init,
    input  logic                        fwd_src,
    output logic [NREGS-1:0][CNTW-1:0]  remain,
    output logic [NREGS-1:0]            fwd_ok
);

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        logic [CNTW-1:0] cnt_q;
        logic            fwd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                fwd_q <= 1'b0;
            end else if (wr_en && wr_mask[gi]) begin
                cnt_q <= wait_init;
                fwd_q <= fwd_src;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign remain[gi] = cnt_q;
        assign fwd_ok[gi] = fwd_q;
    end

endmodule

// File: rtl/scb_hazard.sv
module scb_hazard #(
    parameter int NREGS = 16,
    parameter int CNTW  = 6,
    parameter int IDXW  = 4
) (
    input  logic                        valid,
    input  logic                        exec_busy,
    input  logic                        store_op,
    input  logic                        src0_vld,
    input  logic [IDXW-1:0]             src0,
    input  logic                        src1_vld,
    input  logic [IDXW-1:0]             src1,
    input  logic [NREGS-1:0][CNTW-1:0]  remain,
    input  logic [NREGS-1:0]            fwd_ok,
    output logic                        stall
);

    localparam logic [CNTW-1:0] ONE = CNTW'(1);

    logic [CNTW-1:0] rem0;
    logic [CNTW-1:0] rem1;
    logic            blk0;
    logic            blk1;
    logic            shortcut;

    always_comb begin
        rem0     = remain[src0];
        rem1     = remain[src1];
        shortcut = store_op && fwd_ok[src1] && (rem1 == ONE);
        blk0     = src0_vld && (rem0 != '0);
        blk1     = src1_vld && (rem1 != '0) && !shortcut;
        stall    = valid && (exec_busy || blk0 || blk1);
    end

endmodule

// File: rtl/scb_exec_fsm.sv
module scb_exec_fsm
    import scb_pkg::*;
#(
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [HW-1:0] extra,
    output logic          busy
);

    exec_state_e   state_q;
    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (start) begin
                        state_q <= ST_HOLD;
                        left_q  <= extra - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (left_q == '0) begin
                        state_q <= ST_FREE;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FREE: busy = 1'b0;
            ST_HOLD: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/scb_scoreboard.sv
module scb_scoreboard
    import scb_pkg::*;
#(
    parameter int NREGS      = 16,
    parameter int LAT_ALU    = 1,
    parameter int LAT_SHREG  = 2,
    parameter int LAT_LOAD1  = 2,
    parameter int LAT_LOADM  = 3,
    parameter int LAT_CALL   = 32,
    parameter int SHREG_EXEC = 2,
    parameter int LOADM_EXEC = 3,
    localparam int IDXW      = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [2:0]       iss_class,
    input  logic [NREGS-1:0] iss_dst_mask,
    input  logic             iss_src0_vld,
    input  logic [IDXW-1:0]  iss_src0,
    input  logic             iss_src1_vld,
    input  logic [IDXW-1:0]  iss_src1,
    output logic             iss_stall
);

    localparam int EXEC_MAX  = (SHREG_EXEC > LOADM_EXEC) ? SHREG_EXEC : LOADM_EXEC;
    localparam int HW        = $clog2(EXEC_MAX) + 1;
    localparam int CNTW      = $clog2(LAT_CALL + 1);

    op_class_e                  cls;
    logic [CNTW-1:0]            wait_init;
    logic                       writes;
    logic                       fwd_src;
    logic                       store_op;
    logic [HW-1:0]              extra_busy;
    logic [NREGS-1:0][CNTW-1:0] remain;
    logic [NREGS-1:0]           fwd_ok;
    logic                       exec_busy;
    logic                       fire;

    assign cls  = op_class_e'(iss_class);
    assign fire = iss_valid && !iss_stall;

    scb_class_decode #(
        .CNTW(CNTW), .HW(HW),
        .LAT_ALU(LAT_ALU), .LAT_SHREG(LAT_SHREG), .LAT_LOAD1(LAT_LOAD1),
        .LAT_LOADM(LAT_LOADM), .LAT_CALL(LAT_CALL),
        .SHREG_EXEC(SHREG_EXEC), .LOADM_EXEC(LOADM_EXEC)
    ) u_dec (
        .cls(cls), .wait_init(wait_init), .writes(writes),
        .fwd_src(fwd_src), .store_op(store_op), .extra_busy(extra_busy)
    );

    scb_reg_timers #(.NREGS(NREGS), .CNTW(CNTW)) u_tmr (
        .clk(clk), .rst(rst), .wr_en(fire && writes),
        .wr_mask(iss_dst_mask), .wait_init(wait_init), .fwd_src(fwd_src),
        .remain(remain), .fwd_ok(fwd_ok)
    );

    scb_exec_fsm #(.HW(HW)) u_fsm (
        .clk(clk), .rst(rst), .start(fire && (extra_busy != '0)),
        .extra(extra_busy), .busy(exec_busy)
    );

    scb_hazard #(.NREGS(NREGS), .CNTW(CNTW), .IDXW(IDXW)) u_haz (
        .valid(iss_valid), .exec_busy(exec_busy), .store_op(store_op),
        .src0_vld(iss_src0_vld), .src0(iss_src0),
        .src1_vld(iss_src1_vld), .src1(iss_src1),
        .remain(remain), .fwd_ok(fwd_ok), .stall(iss_stall)
    );

endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
    parameter int NREGS = 16,
    parameter int IDXW  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic [2:0]       iss_class,
    input logic [NREGS-1:0] iss_dst_mask,
    input logic             iss_src0_vld,
    input logic [IDXW-1:0]  iss_src0,
    input logic             iss_src1_vld,
    input logic [IDXW-1:0]  iss_src1,
    input logic             iss_stall
);

    logic             fire;
    logic             call_prev;
    logic [NREGS-1:0] call_mask_prev;
    logic             unused_ok;

    assign fire      = iss_valid && !iss_stall;
    assign unused_ok = iss_src1_vld ^ (^iss_src1);

    always_ff @(posedge clk) begin
        if (rst) begin
            call_prev      <= 1'b0;
            call_mask_prev <= '0;
        end else begin
            call_prev      <= fire && (iss_class == 3'd6);
            call_mask_prev <= iss_dst_mask;
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !iss_stall);

    // R2
    a_r2_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_stall);

    // R3
    a_r3_alu_no_hold: assert property (@(posedge clk) disable iff (rst)
        (fire && iss_class == 3'd0) |=> (iss_src0_vld || iss_src1_vld || !iss_stall));

    // R4
    a_r4_shreg_holds_exec: assert property (@(posedge clk) disable iff (rst)
        (fire && iss_class == 3'd1) |=> (!iss_valid || iss_stall));

    // R9
    a_r9_call_reader_waits: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_src0_vld && call_prev && call_mask_prev[iss_src0]) |-> iss_stall);

endmodule

bind scb_scoreboard scb_checker #(.NREGS(NREGS), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_dst_mask(iss_dst_mask), .iss_src0_vld(iss_src0_vld),
    .iss_src0(iss_src0), .iss_src1_vld(iss_src1_vld), .iss_src1(iss_src1),
    .iss_stall(iss_stall)
);

// File: tb/sim_scb_scoreboard.sv
`timescale 1ns/1ps
module sim_scb_scoreboard;

    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [2:0]    iss_class = 3'd0;
    logic [NR-1:0] iss_dst_mask = '0;
    logic          iss_src0_vld = 1'b0;
    logic [3:0]    iss_src0 = '0;
    logic          iss_src1_vld = 1'b0;
    logic [3:0]    iss_src1 = '0;
    logic          iss_stall;

    int n_cmp = 0;
    int n_bad = 0;

    int m_cnt [NR];
    bit m_fwd [NR];
    int m_hold;

    always #2 clk = ~clk;

    scb_scoreboard u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst_mask(iss_dst_mask), .iss_src0_vld(iss_src0_vld),
        .iss_src0(iss_src0), .iss_src1_vld(iss_src1_vld), .iss_src1(iss_src1),
        .iss_stall(iss_stall)
    );

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 2;
            3'd3: return 3;
            3'd6: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_stall();
        bit b0, b1, sc;
        b0 = iss_src0_vld && (m_cnt[iss_src0] > 0);
        sc = (iss_class == 3'd4) && m_fwd[iss_src1] && (m_cnt[iss_src1] == 1);
        b1 = iss_src1_vld && (m_cnt[iss_src1] > 0) && !sc;
        return iss_valid && ((m_hold > 0) || b0 || b1);
    endfunction

    task automatic model_update(input bit e);
        bit f;
        f = iss_valid && !e;
        if (rst) begin
            for (int i = 0; i < NR; i++) begin m_cnt[i] = 0; m_fwd[i] = 0; end
            m_hold = 0;
        end else begin
            for (int i = 0; i < NR; i++) begin
                if (f && lat_of(iss_class) > 0 && iss_dst_mask[i]) begin
                    m_cnt[i] = lat_of(iss_class) - 1;
                    m_fwd[i] = (iss_class == 3'd2);
                end else if (m_cnt[i] > 0) begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (m_hold > 0) m_hold = m_hold - 1;
            else if (f && iss_class == 3'd1) m_hold = 1;
            else if (f && iss_class == 3'd3) m_hold = 2;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stall=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit dir, input logic dexp);
        bit e;
        #1;
        e = exp_stall();
        check(tag, iss_stall, e);
        if (dir) check(tag, iss_stall, dexp);
        @(posedge clk);
        model_update(e);
        @(negedge clk);
    endtask

    task automatic op(input logic [2:0] c, input logic [NR-1:0] m,
                      input logic v0, input logic [3:0] s0,
                      input logic v1, input logic [3:0] s1);
        iss_valid = 1'b1; iss_class = c; iss_dst_mask = m;
        iss_src0_vld = v0; iss_src0 = s0; iss_src1_vld = v1; iss_src1 = s1;
    endtask

    task automatic do_reset();
        rst = 1'b1; iss_valid = 1'b0;
        step("R1 reset", 1'b0, 1'b0);
        step("R1 reset", 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) begin m_cnt[i] = 0; m_fwd[i] = 0; end
        m_hold = 0;
        @(negedge clk);
        do_reset();

        // R1: clean state, dependent reads issue
        op(3'd0, 16'h0001, 1'b1, 4'd3, 1'b1, 4'd4);
        step("R1 after reset", 1'b1, 1'b0);
        // R3: ALU writes r1, reader next cycle
        op(3'd0, 16'h0002, 1'b0, 4'd0, 1'b0, 4'd0); step("R3 alu", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd1, 1'b0, 4'd0); step("R3 reader", 1'b1, 1'b0);
        // R5: single load r2
        op(3'd2, 16'h0004, 1'b0, 4'd0, 1'b0, 4'd0); step("R5 load", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd2, 1'b0, 4'd0); step("R5 reader early", 1'b1, 1'b1);
        step("R5 reader ready", 1'b1, 1'b0);
        // R6: load r3, store uses r3 as data
        op(3'd2, 16'h0008, 1'b0, 4'd0, 1'b0, 4'd0); step("R6 load", 1'b1, 1'b0);
        op(3'd4, 16'h0000, 1'b1, 4'd0, 1'b1, 4'd3); step("R6 store data fwd", 1'b1, 1'b0);
        // R6: load r4, store uses r4 as address
        op(3'd2, 16'h0010, 1'b0, 4'd0, 1'b0, 4'd0); step("R6 load", 1'b1, 1'b0);
        op(3'd4, 16'h0000, 1'b1, 4'd4, 1'b0, 4'd0); step("R6 store addr", 1'b1, 1'b1);
        step("R6 store addr later", 1'b1, 1'b0);
        // R4: shift-by-register to r5
        op(3'd1, 16'h0020, 1'b0, 4'd0, 1'b0, 4'd0); step("R4 shreg", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b0, 4'd0, 1'b0, 4'd0); step("R4 exec held", 1'b1, 1'b1);
        op(3'd0, 16'h0000, 1'b1, 4'd5, 1'b0, 4'd0); step("R4 reader", 1'b1, 1'b0);
        // R7: multi-load r6..r8
        op(3'd3, 16'h01C0, 1'b0, 4'd0, 1'b0, 4'd0); step("R7 loadm", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd8, 1'b0, 4'd0); step("R7 hold 1", 1'b1, 1'b1);
        step("R7 hold 2", 1'b1, 1'b1);
        step("R7 reader", 1'b1, 1'b0);
        // R8: branch and store with masks write nothing
        op(3'd5, 16'h0800, 1'b0, 4'd0, 1'b0, 4'd0); step("R8 branch", 1'b1, 1'b0);
        op(3'd4, 16'h1000, 1'b1, 4'd11, 1'b0, 4'd0); step("R8 after branch", 1'b1, 1'b0);
        op(3'd7, 16'h0800, 1'b1, 4'd12, 1'b0, 4'd0); step("R8 after store", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd11, 1'b1, 4'd11); step("R8 after nop", 1'b1, 1'b0);
        // R9: call writes r9
        op(3'd6, 16'h0200, 1'b0, 4'd0, 1'b0, 4'd0); step("R9 call", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd9, 1'b0, 4'd0);
        for (int k = 0; k < 31; k++) step("R9 waiting", 1'b1, 1'b1);
        step("R9 issues", 1'b1, 1'b0);
        // R10: call r10 overwritten by ALU
        op(3'd6, 16'h0400, 1'b0, 4'd0, 1'b0, 4'd0); step("R10 call", 1'b1, 1'b0);
        op(3'd0, 16'h0400, 1'b0, 4'd0, 1'b0, 4'd0); step("R10 overwrite", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b1, 4'd10, 1'b0, 4'd0); step("R10 reader", 1'b1, 1'b0);
        // R11: unused source index points to a busy register
        op(3'd6, 16'h2000, 1'b0, 4'd0, 1'b0, 4'd0); step("R11 call", 1'b1, 1'b0);
        op(3'd0, 16'h0000, 1'b0, 4'd13, 1'b0, 4'd13); step("R11 unused src", 1'b1, 1'b0);
        // R2: not valid while a source is busy
        op(3'd0, 16'h0000, 1'b1, 4'd13, 1'b0, 4'd0); iss_valid = 1'b0;
        step("R2 idle", 1'b1, 1'b0);

        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [2:0] c;
            logic [NR-1:0] m;
            r = int'($urandom % 100);
            if (r < 30) c = 3'd0; else if (r < 40) c = 3'd1; else if (r < 55) c = 3'd2;
            else if (r < 62) c = 3'd3; else if (r < 80) c = 3'd4; else if (r < 88) c = 3'd5;
            else if (r < 90) c = 3'd6; else c = 3'd7;
            m = NR'(1) << ($urandom % 6);
            if (c == 3'd3) m = m | (NR'(1) << ($urandom % 6)) | (NR'(1) << ($urandom % 6))
                             | (NR'(1) << (($urandom % 6) + 6));
            op(c, m, 1'($urandom), 4'($urandom % 6), 1'($urandom), 4'($urandom % 6));
            iss_valid = ($urandom % 5) != 0;
            rst = ($urandom % 250) == 0;
            step("R1-model random", 1'b0, 1'b0);
            rst = 1'b0;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule